// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block moves outbound frames from memory to a byte stream under the control of in-memory transmit descriptors. Each descriptor is four 32-bit words: an ownership/status word, a control word with flags and the byte count, the address of the frame buffer, and an optional link to the next descriptor. Software fills a descriptor, hands it to the engine by setting the ownership bit, and then strobes the poll-demand input. The engine walks the ring and sends every owned descriptor it finds. It stops at the first descriptor it does not own.

Every descriptor and buffer access goes over one word-wide memory port. Reads return data one cycle after the request. Frame bytes leave on a valid/ready byte stream that marks the final byte. When a descriptor is finished, the engine writes its status word back with ownership cleared. The abort flag is set in that word if the descriptor could not be sent as a single-buffer frame. Clearing the ownership bit is the only completion signal.

The engine only runs while the start-transmit input is high. While it is low and the engine is idle, the current-descriptor pointer tracks the ring base. The ring continues to the following 16-byte slot, or to the address held in word 3 when chaining is selected, or back to the ring base when the end-of-ring flag is set.

Top module: `txd_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `tx_valid`, `mem_en` and `tx_unavail` are low.
- R2: A cycle with `poll_wr` high while `start_en` is high and the engine is idle causes a read (`mem_en` high, `mem_we` low) of the current descriptor's status word in the very next cycle. A poll made while `start_en` is low causes no memory access until `start_en` goes high, and the fetch then follows.
- R3: If the fetched status word has bit 31 clear, no byte is sent. `tx_unavail` rises in the third cycle after the poll cycle, and the engine makes no further fetch. A later `poll_wr` clears `tx_unavail` from the next cycle on.
- R4: The descriptor words are read at byte offsets 0 (status), 4 (control), 8 (buffer address) and 12 (link). Control bits 10:0 give the frame length in bytes.
- R5: An accepted descriptor produces exactly `length` bytes, taken from increasing buffer addresses. Within a word, bits 7:0 go first. `tx_last` is high on the final byte only.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R7: In the cycle after the final byte is accepted, the engine writes 0x00000000 to the descriptor's status word. Bit 31 is therefore clear in every write.
- R8: A descriptor with length zero, or with control bit 29 (first) or bit 30 (last) clear, sends no byte and gets 0x00008000 written to its status word (bit 15 = aborted).
- R9: After each status write-back, the engine fetches the next descriptor without a new poll while `start_en` is high. By default the next descriptor is at the current address plus 16.
- R10: With control bit 24 set (and bit 25 clear), the next descriptor is at the address read from word 3.
- R11: With control bit 25 set, the next descriptor is at `ring_base`. This takes priority over bit 24.
- R12: `start_en` is sampled only between descriptors. If it is low after a write-back, the engine idles with the poll still pending, and the current pointer follows `ring_base` until `start_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_en | input | 1 | Start-transmit enable |
| ring_base | input | ADDR_W | Byte address of the first descriptor (16-byte aligned) |
| poll_wr | input | 1 | One-cycle poll-demand strobe |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Byte stream ready |
| tx_unavail | output | 1 | Last fetch found a descriptor not owned by the engine |

## Verification
Take the poll strobe to be sampled in cycle c. The status read appears in c+1 and `tx_unavail` rises in c+3 for an unowned descriptor. The first byte is valid in c+7. After the final byte is accepted in cycle s, the write-back comes in s+1 and the next status read in s+2. After the last byte of a word is accepted, the next byte is valid three cycles later. The bench samples on the falling edge. At the falling edge it checks the exact cycles for c+1, c+2, c+3 and c+7, and on every clock it compares each accepted byte and each memory write against queues built from the descriptors it set up. Checks that do not depend on a count of cycles (ownership left intact, status words in memory, no traffic while start is low) are made only after the engine has gone quiet.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int SEL_W      = $clog2(WORD_BYTES);
  localparam int LEN_W      = 11;
  localparam int DESC_BYTES = 4 * WORD_BYTES;

  // status word
  localparam int OWN_BIT    = 31;
  localparam int ABORT_BIT  = 15;
  // control word
  localparam int FIRST_BIT  = 29;
  localparam int LAST_BIT   = 30;
  localparam int RING_END   = 25;
  localparam int CHAIN_BIT  = 24;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHK_OWN,
    ST_GET_CTRL,
    ST_GET_BUF,
    ST_GET_LINK,
    ST_LOAD,
    ST_SEND,
    ST_FETCH,
    ST_WBACK
  } seq_state_e;
endpackage

// File: rtl/txd_poll_flags.sv
module txd_poll_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_wr,
  input  logic found_empty,
  output logic pend,
  output logic unavail
);
  logic pend_q, pend_d;
  logic unav_q, unav_d;

  always_comb begin
    pend_d = poll_wr | (pend_q & ~found_empty);
    unav_d = ~poll_wr & (unav_q | found_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      unav_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      unav_q <= unav_d;
    end
  end

  assign pend    = pend_q;
  assign unavail = unav_q;

  assert_poll_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_wr |=> !unavail);
  assert_empty_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (found_empty && !poll_wr) |=> (unavail && !pend));
endmodule

// File: rtl/txd_byte_stream.sv
module txd_byte_stream
  import txd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_init,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              word_load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              send_en,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  output logic [LEN_W-1:0]  word_off,
  output logic              word_need,
  output logic              frame_done
);
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  len_q;
  logic [WORD_W-1:0] word_q;
  logic              cnt_en;
  logic              beat;
  logic              final_hit;
  logic [SEL_W-1:0]  sel;

  assign sel       = cnt_q[SEL_W-1:0];
  assign final_hit = (cnt_q == len_q - LEN_W'(1));
  assign beat      = send_en & tx_ready;

  always_comb begin
    cnt_en = frame_init | beat;
    cnt_d  = frame_init ? '0 : cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      word_q <= '0;
    end else begin
      if (cnt_en)     cnt_q  <= cnt_d;
      if (frame_init) len_q  <= frame_len;
      if (word_load)  word_q <= word_in;
    end
  end

  assign tx_valid   = send_en;
  assign tx_data    = word_q[{sel, 3'b000} +: BYTE_W];
  assign tx_last    = send_en & final_hit;
  assign word_off   = cnt_q;
  assign frame_done = beat & final_hit;
  assign word_need  = beat & ~final_hit & (sel == {SEL_W{1'b1}});

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    send_en |-> (cnt_q < len_q));
endmodule

// File: rtl/txd_sequencer.sv
module txd_sequencer
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              pend,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [LEN_W-1:0]  word_off,
  input  logic              word_need,
  input  logic              frame_done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              found_empty,
  output logic              frame_init,
  output logic [LEN_W-1:0]  frame_len,
  output logic              word_load,
  output logic              send_en
);
  localparam int PAD_W = ADDR_W - LEN_W;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              cur_en;
  logic [ADDR_W-1:0] buf_q, link_q;
  logic [LEN_W-1:0]  len_q;
  logic              fs_q, ls_q, end_q, chain_q;
  logic              ctrl_en, buf_en, link_en;
  logic              abort_q, abort_d, abort_en;
  logic              frame_ok;
  logic [ADDR_W-1:0] succ_addr;

  assign frame_ok = (len_q != '0) & fs_q & ls_q;

  always_comb begin
    if (end_q)        succ_addr = ring_base;
    else if (chain_q) succ_addr = link_q;
    else              succ_addr = cur_q + ADDR_W'(DESC_BYTES);
  end

  always_comb begin
    state_d     = state_q;
    cur_d       = succ_addr;
    cur_en      = 1'b0;
    ctrl_en     = 1'b0;
    buf_en      = 1'b0;
    link_en     = 1'b0;
    abort_en    = 1'b0;
    abort_d     = 1'b0;
    mem_en      = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = cur_q;
    mem_wdata   = '0;
    found_empty = 1'b0;
    frame_init  = 1'b0;
    word_load   = 1'b0;
    send_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!start_en) begin
          cur_en = 1'b1;
          cur_d  = ring_base;
        end else if (pend) begin
          mem_en  = 1'b1;
          state_d = ST_CHK_OWN;
        end
      end
      ST_CHK_OWN: begin
        if (mem_rdata[OWN_BIT]) begin
          mem_en   = 1'b1;
          mem_addr = cur_q + ADDR_W'(4);
          state_d  = ST_GET_CTRL;
        end else begin
          found_empty = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      ST_GET_CTRL: begin
        ctrl_en  = 1'b1;
        mem_en   = 1'b1;
        mem_addr = cur_q + ADDR_W'(8);
        state_d  = ST_GET_BUF;
      end
      ST_GET_BUF: begin
        buf_en     = 1'b1;
        frame_init = 1'b1;
        mem_en     = 1'b1;
        mem_addr   = cur_q + ADDR_W'(12);
        state_d    = ST_GET_LINK;
      end
      ST_GET_LINK: begin
        link_en  = 1'b1;
        abort_en = 1'b1;
        abort_d  = ~frame_ok;
        if (frame_ok) begin
          mem_en   = 1'b1;
          mem_addr = buf_q;
          state_d  = ST_LOAD;
        end else begin
          state_d  = ST_WBACK;
        end
      end
      ST_LOAD: begin
        word_load = 1'b1;
        state_d   = ST_SEND;
      end
      ST_SEND: begin
        send_en = 1'b1;
        if (frame_done)     state_d = ST_WBACK;
        else if (word_need) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        mem_en   = 1'b1;
        mem_addr = buf_q + {{PAD_W{1'b0}}, word_off};
        state_d  = ST_LOAD;
      end
      ST_WBACK: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = WORD_W'({abort_q, {ABORT_BIT{1'b0}}});
        cur_en    = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign frame_len = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      buf_q   <= '0;
      link_q  <= '0;
      len_q   <= '0;
      fs_q    <= 1'b0;
      ls_q    <= 1'b0;
      end_q   <= 1'b0;
      chain_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cur_en)   cur_q <= cur_d;
      if (buf_en)   buf_q <= mem_rdata[ADDR_W-1:0];
      if (link_en)  link_q <= mem_rdata[ADDR_W-1:0];
      if (abort_en) abort_q <= abort_d;
      if (ctrl_en) begin
        len_q   <= mem_rdata[LEN_W-1:0];
        fs_q    <= mem_rdata[FIRST_BIT];
        ls_q    <= mem_rdata[LAST_BIT];
        end_q   <= mem_rdata[RING_END];
        chain_q <= mem_rdata[CHAIN_BIT];
      end
    end
  end

  assert_own_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> !mem_wdata[OWN_BIT]);
  assert_wb_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (mem_en && mem_we && mem_wdata == '0));
  assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  assert_no_send_on_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    found_empty |=> !send_en);
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              poll_wr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              tx_unavail
);
  logic             pend, found_empty;
  logic             frame_init, word_load, send_en;
  logic [LEN_W-1:0] frame_len, word_off;
  logic             word_need, frame_done;

  txd_poll_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_wr     (poll_wr),
    .found_empty (found_empty),
    .pend        (pend),
    .unavail     (tx_unavail)
  );

  txd_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_en    (start_en),
    .ring_base   (ring_base),
    .pend        (pend),
    .mem_rdata   (mem_rdata),
    .word_off    (word_off),
    .word_need   (word_need),
    .frame_done  (frame_done),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .found_empty (found_empty),
    .frame_init  (frame_init),
    .frame_len   (frame_len),
    .word_load   (word_load),
    .send_en     (send_en)
  );

  txd_byte_stream u_stream (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_init (frame_init),
    .frame_len  (frame_len),
    .word_load  (word_load),
    .word_in    (mem_rdata),
    .send_en    (send_en),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .word_off   (word_off),
    .word_need  (word_need),
    .frame_done (frame_done)
  );

  assert_write_is_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  assert_last_has_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

// File: tb/txd_engine_tb_top.sv
`timescale 1ns/1ps
module txd_engine_tb_top;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] FS  = 32'h2000_0000;
  localparam logic [31:0] LS  = 32'h4000_0000;
  localparam logic [31:0] EOR = 32'h0200_0000;
  localparam logic [31:0] CH  = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_en, poll_wr, tx_ready;
  logic [31:0] ring_base;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_unavail;
  logic [7:0]  tx_data;

  logic [31:0] mem [0:255];
  logic [7:0]  exp_b [$];
  bit          exp_l [$];
  logic [31:0] exp_wa [$];
  logic [31:0] exp_wd [$];
  int n_chk = 0, n_fail = 0, n_mem = 0, cyc = 0;
  bit ready_mode = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  txd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_en(start_en), .ring_base(ring_base),
    .poll_wr(poll_wr), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_unavail(tx_unavail)
  );

  // memory model: read data one cycle after request
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      tx_ready <= ready_mode ? ((cyc % 3) != 2) : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mem_en) n_mem++;
      if (tx_valid && tx_ready) begin
        if (exp_b.size() == 0) check(1'b0, "R5", "unexpected byte", tx_data, 0);
        else begin
          check(tx_data == exp_b[0], "R5", "byte value", tx_data, exp_b[0]);
          check(tx_last == exp_l[0], "R5", "last marker", tx_last, exp_l[0]);
          void'(exp_b.pop_front());
          void'(exp_l.pop_front());
        end
      end
      if (mem_en && mem_we) begin
        if (exp_wa.size() == 0) check(1'b0, "R7", "unexpected write", mem_addr, 0);
        else begin
          check(mem_addr == exp_wa[0], "R7", "write address", mem_addr, exp_wa[0]);
          check(mem_wdata == exp_wd[0], "R8", "write data", mem_wdata, exp_wd[0]);
          void'(exp_wa.pop_front());
          void'(exp_wd.pop_front());
        end
      end
    end
  end

  task automatic put_desc(input int a, input logic [31:0] st, input logic [31:0] ctl,
                          input logic [31:0] bufa, input logic [31:0] lnk);
    mem[a/4] = st; mem[a/4+1] = ctl; mem[a/4+2] = bufa; mem[a/4+3] = lnk;
  endtask

  task automatic fill_buf(input int a, input int n, input int seed, input bit expect_it);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 7) & 255);
      mem[(a + i) / 4][8 * ((a + i) % 4) +: 8] = b;
      if (expect_it) begin
        exp_b.push_back(b);
        exp_l.push_back(i == n - 1);
      end
    end
  endtask

  task automatic push_wr(input logic [31:0] a, input logic [31:0] d);
    exp_wa.push_back(a); exp_wd.push_back(d);
  endtask

  task automatic do_poll();
    @(negedge clk) poll_wr = 1'b1;
    @(negedge clk) poll_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_unavail(input string req);
    int k = 0;
    while (!tx_unavail && k < 3000) begin @(negedge clk); k++; end
    check(tx_unavail == 1'b1, req, "engine stops at unowned descriptor", tx_unavail, 1);
    check(exp_b.size() == 0, "R5", "bytes outstanding", exp_b.size(), 0);
    check(exp_wa.size() == 0, "R7", "writes outstanding", exp_wa.size(), 0);
  endtask

  task automatic first_byte_latency(input string req);
    int k = 1;
    while (!tx_valid && k < 50) begin @(negedge clk); k++; end
    check(k == 7, req, "poll to first byte cycles", k, 7);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int snap;
    rst_n = 1'b0; start_en = 1'b0; poll_wr = 1'b0; ring_base = 32'h100;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    idle(3);
    check(!tx_valid && !mem_en && !tx_unavail, "R1", "outputs in reset",
          {tx_valid, mem_en, tx_unavail}, 0);
    rst_n = 1'b1;
    idle(1);
    check(!tx_valid && !mem_en && !tx_unavail, "R1", "outputs after reset",
          {tx_valid, mem_en, tx_unavail}, 0);
    start_en = 1'b1;
    idle(1);

    // poll with nothing owned: fetch timing and unavailable flag
    do_poll();
    check(mem_en && !mem_we && mem_addr == 32'h100, "R2", "status read after poll",
          mem_addr, 32'h100);
    idle(1);
    check(tx_unavail == 1'b0, "R3", "flag not yet at c+2", tx_unavail, 0);
    idle(1);
    check(tx_unavail == 1'b1, "R3", "flag at c+3", tx_unavail, 1);
    check(mem_en == 1'b0, "R3", "no further fetch", mem_en, 0);
    do_poll();
    check(tx_unavail == 1'b0, "R3", "poll clears flag", tx_unavail, 0);
    idle(2);
    check(tx_unavail == 1'b1, "R3", "flag set again", tx_unavail, 1);
    start_en = 1'b0;
    idle(2);

    // poll while start is low, then single frame
    put_desc(32'h100, OWN, FS | LS | 32'd5, 32'h200, 32'h0);
    put_desc(32'h110, 32'h0, 32'h0, 32'h0, 32'h0);
    fill_buf(32'h200, 5, 11, 1'b1);
    push_wr(32'h100, 32'h0);
    do_poll();
    snap = n_mem;
    idle(10);
    check(n_mem == snap, "R2", "no access while start low", n_mem - snap, 0);
    check(tx_unavail == 1'b0, "R3", "poll cleared flag", tx_unavail, 0);
    start_en = 1'b1;
    wait_unavail("R4");
    check(mem[32'h100 / 4] == 32'h0, "R7", "status written back", mem[32'h100 / 4], 0);

    // end of ring beats chaining; back-pressure
    ready_mode = 1'b1;
    put_desc(32'h110, OWN, FS | LS | EOR | CH | 32'd9, 32'h204, 32'h300);
    put_desc(32'h300, OWN, FS | LS | 32'd3, 32'h3F0, 32'h0);
    fill_buf(32'h204, 9, 40, 1'b1);
    push_wr(32'h110, 32'h0);
    do_poll();
    check(mem_en && mem_addr == 32'h110, "R9", "fetch continues at +16", mem_addr, 32'h110);
    wait_unavail("R11");
    check(mem[32'h300 / 4][31] == 1'b1, "R11", "chained link ignored at ring end",
          mem[32'h300 / 4][31], 1);
    ready_mode = 1'b0;

    // chained link
    put_desc(32'h100, OWN, FS | LS | CH | 32'd4, 32'h240, 32'h340);
    put_desc(32'h110, OWN, FS | LS | 32'd2, 32'h260, 32'h0);
    put_desc(32'h340, OWN, FS | LS | EOR | 32'd6, 32'h280, 32'h0);
    fill_buf(32'h240, 4, 90, 1'b1);
    fill_buf(32'h280, 6, 130, 1'b1);
    push_wr(32'h100, 32'h0);
    push_wr(32'h340, 32'h0);
    do_poll();
    first_byte_latency("R5");
    wait_unavail("R10");
    check(mem[32'h110 / 4][31] == 1'b1, "R10", "sequential slot skipped",
          mem[32'h110 / 4][31], 1);

    // aborted descriptors, sequential walk
    put_desc(32'h100, OWN, FS | LS | 32'd0, 32'h200, 32'h0);
    put_desc(32'h110, OWN, FS | 32'd4, 32'h200, 32'h0);
    put_desc(32'h120, OWN, FS | LS | EOR | 32'd2, 32'h2A0, 32'h0);
    fill_buf(32'h2A0, 2, 200, 1'b1);
    push_wr(32'h100, 32'h8000);
    push_wr(32'h110, 32'h8000);
    push_wr(32'h120, 32'h0);
    do_poll();
    wait_unavail("R8");
    check(mem[32'h100 / 4] == 32'h8000, "R8", "zero length aborted", mem[32'h100 / 4], 32'h8000);
    check(mem[32'h110 / 4] == 32'h8000, "R8", "missing last flag aborted",
          mem[32'h110 / 4], 32'h8000);
    check(mem[32'h120 / 4] == 32'h0, "R9", "third slot sent", mem[32'h120 / 4], 0);

    // start dropped at a descriptor boundary; pointer follows ring base
    put_desc(32'h100, OWN, FS | LS | 32'd3, 32'h2C0, 32'h0);
    put_desc(32'h110, OWN, FS | LS | 32'd3, 32'h2D0, 32'h0);
    fill_buf(32'h2C0, 3, 17, 1'b1);
    fill_buf(32'h2D0, 3, 77, 1'b0);
    push_wr(32'h100, 32'h0);
    do_poll();
    begin
      int k = 0;
      while (!tx_valid && k < 50) begin @(negedge clk); k++; end
    end
    start_en = 1'b0;
    idle(40);
    check(mem[32'h110 / 4][31] == 1'b1, "R12", "next descriptor untouched",
          mem[32'h110 / 4][31], 1);
    check(exp_b.size() == 0 && exp_wa.size() == 0, "R12", "first frame completed",
          exp_b.size() + exp_wa.size(), 0);
    ring_base = 32'h380;
    put_desc(32'h380, OWN, FS | LS | EOR | 32'd2, 32'h3C0, 32'h0);
    fill_buf(32'h3C0, 2, 55, 1'b1);
    push_wr(32'h380, 32'h0);
    idle(2);
    start_en = 1'b1;
    wait_unavail("R12");
    check(mem[32'h110 / 4][31] == 1'b1, "R12", "old ring left alone",
          mem[32'h110 / 4][31], 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule